// File: doc/BRIEF.md
# Vectored Priority Interrupt Aggregator

This block collects interrupt requests from twelve on-board sources and presents one prioritised request to the processor. Each source owns a control byte that holds a sticky pending flag, an enable bit and a 3-bit level. A vector base register and a global enable bit complete the programming model. Requests arrive as one-cycle pulses or as held levels on dedicated inputs. The two software sources have no hardware line; they are raised through a separate set strobe.

The block continuously drives the highest level found among the enabled, pending sources. When the processor runs an acknowledge cycle for a given level, the block returns an 8-bit vector. The vector is the base register plus the fixed index of the winning source, and among equal levels the lowest index wins. The serial source may leave vector delivery to its peripheral. In that case the block flags the acknowledge as external instead of supplying a vector.

Top module: `vic_top`

## Requirements
- R1: After reset every control byte, the vector base and the general control byte read zero (bit 6 of the abort byte shows the live switch input), and `irq_level` is 0.
- R2: A high request on `src_req[i]` (sources 0 to 9) or `soft_set[k]` (sources 10 and 11) sets that source's pending flag (bit 7) at the next clock edge. The flag stays set until it is cleared, and a request in the same cycle as a clearing write leaves it set.
- R3: Writing a source control byte stores bit 3 as enable and bits 2:0 as level. A 1 in bit 7 clears pending, and a 0 in bit 7 leaves it unchanged. A read returns {pending, live, 0, select, enable, level} in bits 7, 6, 5, 4, 3 and 2:0.
- R4: `irq_level` is the largest level among sources that are pending, enabled and have a nonzero level. It is 0 when there are none or when the global enable (bit 4 of the general control byte) is clear.
- R5: While `iack` is high, `vec_hit` is 1 if a qualifying source has level `iack_level`. `vec_out` is then the vector base plus the lowest such source index, modulo 256.
- R6: With `iack` low, or with no qualifying source at `iack_level`, both `vec_hit` and `vec_ext` are 0 and `vec_out` is 0.
- R7: If the serial source (index 3) wins an acknowledge while its bit 4 is 0, the block drives `vec_ext` = 1, `vec_hit` = 0 and `vec_out` = 0. With bit 4 set, it supplies the vector as in R5.
- R8: Bit 6 of the abort byte (index 2) always reflects `abort_sw`, and writes to it have no effect.
- R9: Addresses 0 to 11 select the source control bytes, 12 the vector base and 13 the general control byte, where only bit 4 is stored. Addresses 14 and 15 read 0 and ignore writes.
- R10: Source indices are fixed: AC fail 0, bus error 1, abort 2, serial 3, ethernet 4, SCSI 5, DMA 6, printer 7, timer1 8, timer2 9, soft1 10, soft2 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 10 | Hardware requests for sources 0 to 9 |
| soft_set | input | 2 | Set strobes for sources 10 and 11 |
| abort_sw | input | 1 | Live abort switch state |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_level | output | 3 | Level requested from the processor |
| iack | input | 1 | Acknowledge cycle active |
| iack_level | input | 3 | Level being acknowledged |
| vec_out | output | 8 | Returned vector |
| vec_hit | output | 1 | Block supplies the vector |
| vec_ext | output | 1 | Peripheral supplies the vector |

## Verification
The assertions check, on every cycle, the following properties:
- a request always leaves its flag set;
- a clearing write without a request empties it, and the flag holds otherwise;
- a cleared global enable forces level 0;
- an idle acknowledge returns nothing;
- any supplied vector lies within twelve of the base;
- the selected winner really sits at the acknowledged level.

Only the bench scenarios can show that the winner is the lowest index and that the level is the true maximum across all pairs. The same holds for base wrap-around, the serial hand-off, the live abort bit and the ignored addresses. The bench shows these by sweeping every source at every level and every source pair.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int BYTE_W     = 8;
  localparam int B_PEND     = 7;
  localparam int B_LIVE     = 6;
  localparam int B_SEL      = 4;
  localparam int B_EN       = 3;
  localparam int B_GIE      = 4;
  localparam int IDX_ABORT  = 2;
  localparam int IDX_SERIAL = 3;
  localparam int N_SOFT     = 2;

  typedef logic [BYTE_W-1:0] byte_t;

  // vector = base + source index, wrapping at the byte width
  function automatic byte_t vec_of(byte_t base, int unsigned idx);
    return base + byte_t'(idx);
  endfunction
endpackage

// File: rtl/vic_src_cell.sv
module vic_src_cell
  import vic_pkg::*;
#(
  parameter int LW       = 3,
  parameter bit HAS_SEL  = 1'b0,
  parameter bit HAS_LIVE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  byte_t         wdata,
  input  logic          live,
  output logic          pend,
  output logic          en,
  output logic [LW-1:0] lvl,
  output logic          ext,
  output byte_t         rbyte
);
  logic clr_hit;
  logic sel;
  logic unused_wbits;

  assign clr_hit      = wr & wdata[B_PEND];
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      en   <= 1'b0;
      lvl  <= '0;
    end else begin
      pend <= (pend & ~clr_hit) | req;
      if (wr) begin
        en  <= wdata[B_EN];
        lvl <= wdata[LW-1:0];
      end
    end
  end

  generate
    if (HAS_SEL) begin : g_sel
      always_ff @(posedge clk) begin
        if (!rst_n)  sel <= 1'b0;
        else if (wr) sel <= wdata[B_SEL];
      end
      assign ext = ~sel;
    end else begin : g_nosel
      assign sel = 1'b0;
      assign ext = 1'b0;
    end
  endgenerate

  always_comb begin
    rbyte         = '0;
    rbyte[LW-1:0] = lvl;
    rbyte[B_EN]   = en;
    rbyte[B_SEL]  = sel;
    rbyte[B_LIVE] = live & HAS_LIVE;
    rbyte[B_PEND] = pend;
  end

  // R2: a request always leaves the flag set
  p_req_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> pend);
  // R3: a clearing write without a request empties the flag
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata[B_PEND] && !req) |=> !pend);
  // R3: with neither write-clear nor request the flag holds
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_hit && !req) |=> $stable(pend));
endmodule

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
  parameter int NSRC = 12,
  parameter int LW   = 3,
  localparam int IW  = $clog2(NSRC)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          cand,
  input  logic [NSRC-1:0][LW-1:0]  lvls,
  input  logic [LW-1:0]            ack_lvl,
  output logic [LW-1:0]            max_l,
  output logic                     hit,
  output logic [IW-1:0]            idx
);
  always_comb begin
    max_l = '0;
    for (int i = 0; i < NSRC; i++)
      if (cand[i] && (lvls[i] > max_l)) max_l = lvls[i];
  end

  // scan from the top so the lowest index is the last to overwrite
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (cand[i] && (lvls[i] == ack_lvl)) begin
        hit = 1'b1;
        idx = IW'(i);
      end
  end

  // R5: the chosen source is a candidate at the acknowledged level
  p_winner_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (cand[idx] && (lvls[idx] == ack_lvl)));
  // R4: an acknowledged level never exceeds the requested maximum
  p_ack_below_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (ack_lvl <= max_l));
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int NSRC = 12,
  parameter int LW   = 3,
  parameter int AW   = 4,
  localparam int NHW = NSRC - N_SOFT,
  localparam int IW  = $clog2(NSRC)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NHW-1:0] src_req,
  input  logic [N_SOFT-1:0] soft_set,
  input  logic           abort_sw,
  input  logic           reg_we,
  input  logic [AW-1:0]  reg_addr,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  output logic [LW-1:0]  irq_level,
  input  logic           iack,
  input  logic [LW-1:0]  iack_level,
  output logic [7:0]     vec_out,
  output logic           vec_hit,
  output logic           vec_ext
);
  localparam logic [AW-1:0] A_BASE = AW'(NSRC);
  localparam logic [AW-1:0] A_GCR  = AW'(NSRC + 1);

  logic [NSRC-1:0]         req_v, wr_v, pend_v, en_v, ext_v, cand;
  logic [NSRC-1:0][LW-1:0] lvl_v;
  byte_t                   rbyte_v [NSRC];
  byte_t                   base;
  logic                    gie;
  logic [LW-1:0]           max_l;
  logic                    hit;
  logic [IW-1:0]           idx;

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_src
      if (gi < NHW) begin : g_hw
        assign req_v[gi] = src_req[gi];
      end else begin : g_sw
        assign req_v[gi] = soft_set[gi - NHW];
      end
      assign wr_v[gi] = reg_we && (reg_addr == AW'(gi));
      assign cand[gi] = gie && pend_v[gi] && en_v[gi] && (lvl_v[gi] != '0);

      vic_src_cell #(
        .LW      (LW),
        .HAS_SEL (gi == IDX_SERIAL),
        .HAS_LIVE(gi == IDX_ABORT)
      ) u_cell (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (req_v[gi]),
        .wr   (wr_v[gi]),
        .wdata(reg_wdata),
        .live (abort_sw),
        .pend (pend_v[gi]),
        .en   (en_v[gi]),
        .lvl  (lvl_v[gi]),
        .ext  (ext_v[gi]),
        .rbyte(rbyte_v[gi])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base <= '0;
      gie  <= 1'b0;
    end else if (reg_we) begin
      if (reg_addr == A_BASE) base <= reg_wdata;
      if (reg_addr == A_GCR)  gie  <= reg_wdata[B_GIE];
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NSRC; i++)
      if (reg_addr == AW'(i)) reg_rdata = rbyte_v[i];
    if (reg_addr == A_BASE) reg_rdata = base;
    if (reg_addr == A_GCR)  reg_rdata[B_GIE] = gie;
  end

  vic_prio_pick #(.NSRC(NSRC), .LW(LW)) u_pick (
    .clk    (clk),
    .rst_n  (rst_n),
    .cand   (cand),
    .lvls   (lvl_v),
    .ack_lvl(iack_level),
    .max_l  (max_l),
    .hit    (hit),
    .idx    (idx)
  );

  logic ack_win, ack_ext;
  assign ack_win   = iack && hit;
  assign ack_ext   = ack_win && ext_v[idx];
  assign irq_level = max_l;
  assign vec_ext   = ack_ext;
  assign vec_hit   = ack_win && !ack_ext;
  assign vec_out   = vec_hit ? vec_of(base, idx) : '0;

  // R4: a cleared global enable silences the request level
  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> (irq_level == '0));
  // R6: no acknowledge, no answer
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !iack |-> (!vec_hit && !vec_ext && vec_out == '0));
  // R5: a supplied vector lies inside the window above the base
  p_vec_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_hit |-> (byte_t'(vec_out - base) < byte_t'(NSRC)));
  // R7: internal and external delivery exclude each other
  p_one_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_hit && vec_ext));
endmodule

// File: tb/sim_vic_top.sv
module sim_vic_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] src_req = '0;
  logic [1:0] soft_set = '0;
  logic       abort_sw = 1'b0;
  logic       reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [2:0] irq_level;
  logic       iack = 1'b0;
  logic [2:0] iack_level = '0;
  logic [7:0] vec_out;
  logic       vec_hit, vec_ext;
  int nchk = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  vic_top u0 (.*);

  function automatic void chk(string tag, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a[3:0]; reg_wdata = d[7:0];
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic fire(input int i);
    @(negedge clk);
    if (i < 10) src_req[i] = 1'b1; else soft_set[i-10] = 1'b1;
    @(negedge clk);
    src_req = '0; soft_set = '0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    reg_addr = a[3:0]; #1; d = reg_rdata;
  endtask

  task automatic ack(input int l, output logic h, output logic x, output logic [7:0] v);
    iack = 1'b1; iack_level = l[2:0]; #1;
    h = vec_hit; x = vec_ext; v = vec_out;
    iack = 1'b0; #1;
  endtask

  function automatic int ctl_of(int i, int l);
    return (i == 3) ? (8'h18 | l) : (8'h08 | l);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog got=hung exp=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] d, v;
    logic h, x;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq_level", irq_level, 0);
    for (int a = 0; a < 16; a++) begin
      rd(a, d);
      chk("R1 reset read", d, 0);
    end

    base = 8'h40;
    wr(12, base);
    wr(13, 8'h10);
    // R2 R4 R5 R10: every source at every level
    for (int i = 0; i < 12; i++) begin
      for (int l = 1; l < 8; l++) begin
        wr(i, ctl_of(i, l));
        fire(i);
        rd(i, d);
        chk("R3 readback", d, 8'h80 | ctl_of(i, l));
        chk("R4 single level", irq_level, l);
        ack(l, h, x, v);
        chk("R5 single hit", h, 1);
        chk("R10 single vector", v, (base + i) & 8'hff);
        wr(i, 8'h80);
        chk("R3 cleared level", irq_level, 0);
      end
    end

    // R4 R5: every pair, ties go to the lower index
    for (int i = 0; i < 12; i++) begin
      for (int j = i + 1; j < 12; j++) begin
        int li, lj, mx, mn, wmax, wmin;
        li = 1 + (i % 7);
        lj = 1 + ((j * 3) % 7);
        mx = (li >= lj) ? li : lj;
        mn = (li >= lj) ? lj : li;
        wmax = (li >= lj) ? i : j;
        wmin = (li >= lj) ? j : i;
        wr(i, ctl_of(i, li));
        wr(j, ctl_of(j, lj));
        fire(j);
        fire(i);
        chk("R4 pair max", irq_level, mx);
        ack(mx, h, x, v);
        chk("R5 pair winner", v, (base + wmax) & 8'hff);
        if (mn != mx) begin
          ack(mn, h, x, v);
          chk("R5 lower level", v, (base + wmin) & 8'hff);
        end
        wr(i, 8'h80);
        wr(j, 8'h80);
      end
    end

    // R6: acknowledge of an empty level and with iack low
    wr(6, 8'h0e);
    fire(6);
    ack(3, h, x, v);
    chk("R6 empty level hit", h, 0);
    chk("R6 empty level vec", v, 0);
    iack = 1'b0; iack_level = 3'd6; #1;
    chk("R6 iack low", vec_hit, 0);
    // R4: global enable off then on
    wr(13, 8'h00);
    chk("R4 gie off", irq_level, 0);
    ack(6, h, x, v);
    chk("R6 gie off ack", h, 0);
    wr(13, 8'h10);
    chk("R4 gie on", irq_level, 6);
    wr(6, 8'h80);

    // R3: write with bit7 = 0 keeps pending
    wr(1, 8'h0a);
    fire(1);
    wr(1, 8'h0c);
    rd(1, d);
    chk("R3 keep pending", d, 8'h8c);
    chk("R3 new level", irq_level, 4);
    // R2: request beats a clearing write in the same cycle
    @(negedge clk);
    src_req[1] = 1'b1; reg_we = 1'b1; reg_addr = 4'd1; reg_wdata = 8'h8c;
    @(negedge clk);
    src_req = '0; reg_we = 1'b0;
    rd(1, d);
    chk("R2 set beats clear", d, 8'h8c);
    wr(1, 8'h80);
    rd(1, d);
    chk("R3 clear", d, 8'h00);

    // R4: level 0 never requests
    wr(5, 8'h08);
    fire(5);
    chk("R4 level zero", irq_level, 0);
    wr(5, 8'h80);

    // R7: serial hands vector to its peripheral
    wr(3, 8'h0d);
    fire(3);
    ack(5, h, x, v);
    chk("R7 ext flag", x, 1);
    chk("R7 no hit", h, 0);
    chk("R7 vec zero", v, 0);
    wr(3, 8'h1d);
    ack(5, h, x, v);
    chk("R7 supplied", v, (base + 3) & 8'hff);
    chk("R7 ext low", x, 0);
    wr(3, 8'h80);

    // R8: live abort bit
    abort_sw = 1'b1;
    rd(2, d);
    chk("R8 live high", d, 8'h40);
    wr(2, 8'h00);
    rd(2, d);
    chk("R8 write ignored", d, 8'h40);
    abort_sw = 1'b0;
    rd(2, d);
    chk("R8 live low", d, 8'h00);

    // R9: address map
    wr(14, 8'hff);
    rd(14, d);
    chk("R9 addr14", d, 0);
    wr(15, 8'hff);
    rd(15, d);
    chk("R9 addr15", d, 0);
    wr(13, 8'hff);
    rd(13, d);
    chk("R9 gcr bits", d, 8'h10);
    rd(12, d);
    chk("R9 base read", d, base);

    // R5: base wraps
    wr(12, 8'hfa);
    wr(11, 8'h0f);
    fire(11);
    ack(7, h, x, v);
    chk("R5 wrap", v, 8'h05);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule